// File: doc/BRIEF.md
# Write-only I2C Command Receiver

This block is the receive side of a peripheral that only ever accepts writes over a two-wire I2C bus. It samples SCL and SDA with the system clock and finds START and STOP conditions. After a START it reads a 7-bit device address followed by a direction bit. The direction bit must be 0 for a write. When the address matches the `DEVICE_ID` parameter, the block acknowledges the address byte and every byte after it until STOP.

There is no subaddress or register pointer. Each payload byte is handed on as a self-contained command: an 8-bit value plus a single-cycle strobe. The surrounding logic decodes the command. The SDA output is open-drain: the block only ever asks for the line to be pulled low. It assumes a system clock at least 20 times faster than the bus bit rate, and the bus runs at up to 100 kbit/s.

Top module: `i2c_cmd_sink`

## Requirements
- R1: After reset the block does not pull SDA low and gives no byte strobe.
- R2: SDA falling while SCL is high is a START, which begins address reception. SDA rising while SCL is high is a STOP. After a STOP, clocked bits produce neither an acknowledge nor a strobe until the next START.
- R3: The first byte after START is shifted in MSB first: seven address bits, then the direction bit in bit position 0. When the seven bits equal `DEVICE_ID` and the direction bit is 0, the block pulls SDA low for the whole high phase of the ninth SCL pulse.
- R4: Each data byte after an accepted address is delivered MSB first on `cmd_data_o` with a `cmd_valid_o` pulse exactly one cycle long. Any number of bytes may follow, and each one is acknowledged.
- R5: The strobe for a data byte comes after the eighth bit is sampled and before the rising edge of the ninth (acknowledge) clock. The address byte never produces a strobe.
- R6: When the address does not match, SDA is left released on the ninth clock. Later bytes get no acknowledge and no strobe until the next START or STOP.
- R7: A matching address with the direction bit set to 1 (read) is not acknowledged and is ignored in the same way as in R6.
- R8: A repeated START at any point, including in the middle of a data byte or while ignoring the bus, restarts address reception.
- R9: A STOP in the middle of a byte discards the partial byte and gives no strobe.
- R10: The acknowledge pull-down begins only after an SCL falling edge. It is released after the falling edge that ends the ninth clock, before the next bit's rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 20x the bus bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad (wired level) |
| sda_pull_o | output | 1 | 1 asks the open-drain pad to pull SDA low |
| cmd_data_o | output | 8 | Last received command byte |
| cmd_valid_o | output | 1 | One-cycle strobe when a command byte is complete |

## Verification
The main write path is driven with the byte values 0xA5, 0x3C, 0x00 and 0xFF. Together these catch bit-order reversal, stuck bits and off-by-one shifting. Three address bytes are tried: the correct write address, a neighbouring address that differs only in bit 1, and the correct address with the read bit set. This separates full-address comparison from a check of the direction bit. Repeated STARTs are issued mid-byte and from the ignore state, and a STOP is issued mid-byte. These runs show whether the framing logic really resets the bit count and suppresses partial bytes. Every ninth clock is sampled twice while SCL is high and once after it falls, which pins down when the pull-down starts and ends.

// File: rtl/i2c_cmd_pkg.sv
`timescale 1ns/1ps
// Package: i2c_cmd_pkg
// Shared types for the write-only I2C command receiver.
package i2c_cmd_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_ADDR,
        RX_DATA,
        RX_ACK,
        RX_SKIP
    } rx_state_t;
endpackage

// File: rtl/i2c_cmd_sync.sv
`timescale 1ns/1ps
// Module: i2c_cmd_sync
// Brings SCL and SDA into the system clock domain through a flop chain.
// Reports the synchronized levels, SCL edges, and START/STOP events.
// Assumes: STAGES >= 2, and the system clock is fast enough that every
// bus phase lasts several cycles.
module i2c_cmd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] lvl_q;

    assign raw = {sda_raw, scl_raw};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        // Shift the pad level through the synchronizer chain (idle bus is high).
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign lvl[g] = chain[STAGES-1];
    end

    // Keep the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '1;
        else        lvl_q <= lvl;
    end

    assign scl_lvl   = lvl[0];
    assign sda_lvl   = lvl[1];
    assign scl_rise  =  lvl[0] & ~lvl_q[0];
    assign scl_fall  = ~lvl[0] &  lvl_q[0];
    assign start_evt =  lvl[0] &  lvl_q[0] &  lvl_q[1] & ~lvl[1];
    assign stop_evt  =  lvl[0] &  lvl_q[0] & ~lvl_q[1] &  lvl[1];
endmodule

// File: rtl/i2c_cmd_fsm.sv
`timescale 1ns/1ps
// Module: i2c_cmd_fsm
// Byte framing, address check, acknowledge sequencing and command strobe.
// Assumes: inputs come from i2c_cmd_sync. START/STOP take priority over
// bit activity.
module i2c_cmd_fsm
    import i2c_cmd_pkg::*;
#(
    parameter logic [6:0] DEVICE_ID = 7'h44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    output logic              sda_pull,
    output logic [BYTE_W-1:0] cmd_data,
    output logic              cmd_valid
);
    localparam int                CNT_W   = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0]  LAST    = CNT_W'(BYTE_W - 1);
    localparam logic [BYTE_W-1:0] WR_WORD = BYTE_W'({DEVICE_ID, 1'b0});

    rx_state_t         state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] shreg_nx;

    // Shift register value with the bit being sampled now appended.
    assign shreg_nx = {shreg[BYTE_W-2:0], sda_lvl};

    // Framing state machine: bit counting, address match, ack and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            sda_pull  <= 1'b0;
            cmd_data  <= '0;
            cmd_valid <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            if (start_evt) begin
                state    <= RX_ADDR;
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
            end else if (stop_evt) begin
                state    <= RX_IDLE;
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
            end else begin
                case (state)
                    RX_ADDR, RX_DATA: begin
                        if (scl_rise) begin
                            shreg   <= shreg_nx;
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == LAST) begin
                                bit_cnt <= '0;
                                if (state == RX_DATA) begin
                                    cmd_data  <= shreg_nx;
                                    cmd_valid <= 1'b1;
                                    state     <= RX_ACK;
                                end else if (shreg_nx == WR_WORD) begin
                                    state <= RX_ACK;
                                end else begin
                                    state <= RX_SKIP;
                                end
                            end
                        end
                    end
                    RX_ACK: begin
                        if (scl_fall) begin
                            if (!sda_pull) begin
                                sda_pull <= 1'b1;
                            end else begin
                                sda_pull <= 1'b0;
                                state    <= RX_DATA;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R10: pull-down only begins right after an SCL falling edge.
    assert_pull_after_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> $past(scl_fall));

    // R10: release only after an SCL fall or a bus condition.
    assert_release_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull) |-> $past(scl_fall || start_evt || stop_evt));

    // R4: the command strobe is a single-cycle pulse.
    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R5: the strobe follows a sampling edge and precedes the ack drive.
    assert_strobe_on_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($past(scl_rise) && !sda_pull && !scl_lvl == 1'b0));
endmodule

// File: rtl/i2c_cmd_sink.sv
`timescale 1ns/1ps
// Module: i2c_cmd_sink
// Top of the write-only I2C command receiver: synchronizer plus framing FSM.
// Assumes: the system clock is at least 20x the bus bit rate, and the pad
// turns sda_pull_o into an open-drain low.
module i2c_cmd_sink #(
    parameter logic [6:0] DEVICE_ID   = 7'h44,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    output logic [7:0] cmd_data_o,
    output logic       cmd_valid_o
);
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;

    i2c_cmd_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_i),
        .sda_raw   (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    i2c_cmd_fsm #(.DEVICE_ID(DEVICE_ID)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .sda_pull  (sda_pull_o),
        .cmd_data  (cmd_data_o),
        .cmd_valid (cmd_valid_o)
    );
endmodule

// File: tb/i2c_cmd_sink_tb.sv
`timescale 1ns/1ps
// Directed bench for i2c_cmd_sink: a bus master model plus one task per scenario.
module i2c_cmd_sink_tb_top;
    localparam int         CLK_PERIOD = 10;
    localparam int         PH         = 10;     // system clocks per bus phase
    localparam logic [6:0] DEV        = 7'h44;
    localparam int         WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_pull;
    logic [7:0] cmd_data;
    logic cmd_valid;
    logic sda_bus;

    int n_chk = 0;
    int n_fail = 0;
    int n_strobe = 0;
    logic [7:0] last_byte = 8'h00;
    bit done = 1'b0;

    assign sda_bus = m_sda & ~sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_cmd_sink #(.DEVICE_ID(DEV)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (m_scl),
        .sda_i       (sda_bus),
        .sda_pull_o  (sda_pull),
        .cmd_data_o  (cmd_data),
        .cmd_valid_o (cmd_valid)
    );

    // Strobe monitor, sampling away from the active edge.
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            n_strobe  <= n_strobe + 1;
            last_byte <= cmd_data;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(PH);
        m_scl = 1'b1; tick(PH);
        m_sda = 1'b0; tick(PH);
        m_scl = 1'b0; tick(PH);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(PH);
        m_scl = 1'b1; tick(PH);
        m_sda = 1'b1; tick(PH);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b;    tick(PH);
        m_scl = 1'b1; tick(PH);
        m_scl = 1'b0; tick(PH);
    endtask

    // Sends a byte plus ack clock; checks ack, strobe count/value and release.
    task automatic send_byte(input logic [7:0] b, input bit exp_ack,
                             input bit exp_strobe, input string tag);
        int s0;
        s0 = n_strobe;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; tick(PH);
        check((n_strobe - s0) == int'(exp_strobe), "R5 strobe before ack clock", n_strobe - s0, int'(exp_strobe));
        if (exp_strobe) check(last_byte == b, {tag, " byte value"}, last_byte, b);
        m_scl = 1'b1; tick(PH/2);
        check(sda_bus == !exp_ack, {tag, " ack early"}, sda_bus, !exp_ack);
        tick(PH/2 - 1);
        check(sda_bus == !exp_ack, {tag, " ack late"}, sda_bus, !exp_ack);
        m_scl = 1'b0; tick(PH);
        check(sda_pull == 1'b0, "R10 release after ninth clock", sda_pull, 0);
    endtask

    task automatic t_reset();
        check(sda_pull == 1'b0, "R1 sda released", sda_pull, 0);
        check(n_strobe == 0, "R1 no strobe", n_strobe, 0);
    endtask

    task automatic t_write();
        bus_start();
        send_byte({DEV, 1'b0}, 1, 0, "R3");
        send_byte(8'hA5, 1, 1, "R4");
        send_byte(8'h3C, 1, 1, "R4");
        send_byte(8'h00, 1, 1, "R4");
        send_byte(8'hFF, 1, 1, "R4");
        bus_stop();
        check(n_strobe == 4, "R4 strobe count", n_strobe, 4);
    endtask

    task automatic t_bad_addr();
        int s0;
        s0 = n_strobe;
        bus_start();
        send_byte({DEV ^ 7'h01, 1'b0}, 0, 0, "R6 address");
        send_byte(8'h12, 0, 0, "R6 data");
        bus_stop();
        check(n_strobe == s0, "R6 ignored bytes", n_strobe, s0);
    endtask

    task automatic t_read_bit();
        bus_start();
        send_byte({DEV, 1'b1}, 0, 0, "R7 address");
        send_byte(8'h34, 0, 0, "R7 data");
        bus_stop();
    endtask

    task automatic t_restart();
        int s0;
        s0 = n_strobe;
        bus_start();
        send_byte({DEV, 1'b0}, 1, 0, "R8");
        send_byte(8'h55, 1, 1, "R8");
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_start();
        send_byte({DEV, 1'b0}, 1, 0, "R8 restart address");
        send_byte(8'h66, 1, 1, "R8 restart data");
        bus_start();
        send_byte({DEV ^ 7'h10, 1'b0}, 0, 0, "R8 skip");
        bus_start();
        send_byte({DEV, 1'b0}, 1, 0, "R8 restart from skip");
        send_byte(8'h99, 1, 1, "R8 data after skip");
        bus_stop();
        check(n_strobe == s0 + 3, "R8 strobe count", n_strobe, s0 + 3);
    endtask

    task automatic t_stop_mid();
        int s0;
        s0 = n_strobe;
        bus_start();
        send_byte({DEV, 1'b0}, 1, 0, "R9");
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        bus_stop();
        check(n_strobe == s0, "R9 partial byte dropped", n_strobe, s0);
        m_scl = 1'b0; tick(PH);
        send_byte(8'h77, 0, 0, "R2 no start");
        send_byte(8'h88, 0, 0, "R2 no start");
        bus_stop();
        bus_start();
        send_byte({DEV, 1'b0}, 1, 0, "R2 new start");
        send_byte(8'h5A, 1, 1, "R2 new start");
        bus_stop();
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_write();
        t_bad_addr();
        t_read_bit();
        t_restart();
        t_stop_mid();
        tick(20);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule